// File: doc/BRIEF.md
# Dual-Clock FIFO with Ready Flags

This block is a small first-in first-out store, 16 words deep and 4 bits wide by default, whose writing and reading sides run on two unrelated clocks. Each rising edge of the load clock captures the word on the data inputs unless the store is full. Each rising edge of the unload clock retires the oldest word unless the store is empty. The data outputs always show the oldest unread word, so a consumer can sample it before issuing the edge that removes it.

Two ready flags report the state to the outside. The input-ready flag means "a word may be loaded" and is raised only while the load clock sits low. The output-ready flag means "a word is available" and is raised only while the unload clock sits high. Read and write positions cross between the domains as Gray code through two-stage synchronizers, and each side judges full or empty against its own, possibly stale, copy of the other side's position. An active-low clear empties the store. Each domain enters clear at once and leaves it only after two edges of its own clock. A separate output enable floats the data outputs without touching either flag.

Top module: `lfifo_top`

## Requirements
- R1: Words leave in the order they were loaded, and up to 16 words (DEPTH) can be held at once.
- R2: With 16 unread words stored, input-ready is low and load-clock edges change nothing in the store. Words offered during those edges never appear at the outputs.
- R3: With no unread word, output-ready is low and unload-clock edges change nothing: a word loaded later is still read next.
- R4: Input-ready is low whenever the load clock is high, even when the store has room.
- R5: Output-ready is low whenever the unload clock is low, even when a word is stored.
- R6: While clear (`clr_n`) is low, output-ready is low and input-ready is high whenever the load clock is low. All stored words are discarded.
- R7: After clear is released, the first two edges of each clock are ignored. A domain starts working from its third edge.
- R8: With output enable low, the data outputs are high impedance and do not show the stored word. Both flags behave as with output enable high.
- R9: While output enable is high and the store holds a word, the data outputs show the oldest unread word before the unload edge that removes it.
- R10: A word loaded into an empty store becomes visible to the reading side at the second following unload edge. Output-ready stays low after the first of those edges. Space freed by reads reaches the writing side in the same two-edge way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ld_clk | input | 1 | Load clock; rising edge stores `din` |
| un_clk | input | 1 | Unload clock; rising edge retires the oldest word |
| clr_n | input | 1 | Active-low clear, asynchronous entry |
| oe | input | 1 | Output enable for `q`; low floats `q` |
| din | input | WIDTH | Word to load |
| q | output | WIDTH | Oldest unread word, or high impedance |
| in_rdy | output | 1 | Room available, qualified by load clock low |
| out_rdy | output | 1 | Word available, qualified by unload clock high |

## Verification
Short bursts of distinct words show whether ordering and the oldest-word display are right. Extra unload pulses at empty, followed by a fresh load, show whether a pointer slipped past the writer. A burst of 16 words, followed by loads of deliberately different values, separates a correctly blocked full store from one that wraps and overwrites its head. The bench also checks each flag in both phases of its own clock, and counts the unload edges needed before a new word shows. Clear is tried with words still stored and with clock edges just after release, so that stale data and early restart show up as wrong output values or flags.

// File: rtl/lfifo_pkg.sv
package lfifo_pkg;

    localparam int unsigned DEF_WIDTH = 4;
    localparam int unsigned DEF_DEPTH = 16;
    localparam int unsigned PMAX      = 16;

    typedef logic [PMAX-1:0] pword_t;

    function automatic pword_t bin2gray(pword_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic pword_t gray2bin(pword_t g);
        pword_t b;
        b[PMAX-1] = g[PMAX-1];
        for (int i = PMAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/lfifo_sync.sv
module lfifo_sync #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/lfifo_rst_sync.sv
module lfifo_rst_sync (
    input  logic clk,
    input  logic clr_n,
    output logic rst
);
    logic [1:0] hold;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            hold <= 2'b11;
        end else begin
            hold <= {hold[0], 1'b0};
        end
    end

    assign rst = hold[1];
endmodule

// File: rtl/lfifo_store.sv
module lfifo_store #(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             wclk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/lfifo_wr_ctrl.sv
module lfifo_wr_ctrl
    import lfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] rgray_sync,
    output logic          full,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray
);
    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } ptr_t;

    localparam logic [PW-1:0] CAP = PW'(DEPTH);

    ptr_t          wp;
    ptr_t          wp_nx;
    logic [PW-1:0] full_pat;
    logic [PW-1:0] rs_bin;

    always_comb begin
        full_pat   = {~rgray_sync[PW-1:PW-2], rgray_sync[PW-3:0]};
        full       = (wp.gray == full_pat);
        we         = !full && !rst;
        wp_nx.bin  = wp.bin + 1'b1;
        wp_nx.gray = PW'(bin2gray(pword_t'(wp_nx.bin)));
        rs_bin     = PW'(gray2bin(pword_t'(rgray_sync)));
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            wp <= '0;
        end else if (we) begin
            wp <= wp_nx;
        end
    end

    assign waddr = wp.bin[AW-1:0];
    assign wgray = wp.gray;

    // R1
    occupancy_wr_chk: assert property (@(posedge clk) disable iff (rst)
        PW'(wp.bin - rs_bin) <= CAP);

    // R2
    blocked_wr_chk: assert property (@(posedge clk) disable iff (rst)
        full |=> $stable(wp.bin));
endmodule

// File: rtl/lfifo_rd_ctrl.sv
module lfifo_rd_ctrl
    import lfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] wgray_sync,
    output logic          empty,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray
);
    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } ptr_t;

    localparam logic [PW-1:0] CAP = PW'(DEPTH);

    ptr_t          rp;
    ptr_t          rp_nx;
    logic          re;
    logic [PW-1:0] ws_bin;

    always_comb begin
        empty      = (rp.gray == wgray_sync);
        re         = !empty && !rst;
        rp_nx.bin  = rp.bin + 1'b1;
        rp_nx.gray = PW'(bin2gray(pword_t'(rp_nx.bin)));
        ws_bin     = PW'(gray2bin(pword_t'(wgray_sync)));
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            rp <= '0;
        end else if (re) begin
            rp <= rp_nx;
        end
    end

    assign raddr = rp.bin[AW-1:0];
    assign rgray = rp.gray;

    // R1
    occupancy_rd_chk: assert property (@(posedge clk) disable iff (rst)
        PW'(ws_bin - rp.bin) <= CAP);

    // R3
    blocked_rd_chk: assert property (@(posedge clk) disable iff (rst)
        empty |=> $stable(rp.bin));
endmodule

// File: rtl/lfifo_top.sv
module lfifo_top
    import lfifo_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH,
    parameter int unsigned DEPTH = DEF_DEPTH,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned PW   = AW + 1
) (
    input  logic             ld_clk,
    input  logic             un_clk,
    input  logic             clr_n,
    input  logic             oe,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             in_rdy,
    output logic             out_rdy
);
    logic          wr_rst;
    logic          rd_rst;
    logic          full;
    logic          empty;
    logic          we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [PW-1:0] wgray;
    logic [PW-1:0] rgray;
    logic [PW-1:0] wgray_at_rd;
    logic [PW-1:0] rgray_at_wr;
    logic [WIDTH-1:0] head;

    lfifo_rst_sync u_wr_rst (.clk(ld_clk), .clr_n(clr_n), .rst(wr_rst));
    lfifo_rst_sync u_rd_rst (.clk(un_clk), .clr_n(clr_n), .rst(rd_rst));

    lfifo_sync #(.W(PW)) u_r2w (
        .clk(ld_clk), .rst(wr_rst), .d(rgray), .q(rgray_at_wr));
    lfifo_sync #(.W(PW)) u_w2r (
        .clk(un_clk), .rst(rd_rst), .d(wgray), .q(wgray_at_rd));

    lfifo_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk(ld_clk), .rst(wr_rst), .rgray_sync(rgray_at_wr),
        .full(full), .we(we), .waddr(waddr), .wgray(wgray));

    lfifo_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .clk(un_clk), .rst(rd_rst), .wgray_sync(wgray_at_rd),
        .empty(empty), .raddr(raddr), .rgray(rgray));

    lfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
        .wclk(ld_clk), .we(we), .waddr(waddr), .wdata(din),
        .raddr(raddr), .rdata(head));

    assign in_rdy  = !full && !ld_clk;
    assign out_rdy = !empty && !rd_rst && un_clk;
    assign q       = oe ? head : {WIDTH{1'bz}};
endmodule

// File: tb/tb_lfifo_top.sv
`timescale 1ns/1ps
module tb_lfifo_top;
    localparam real HALF = 4.0;  // 125 MHz pulses

    logic       ld_clk = 1'b0;
    logic       un_clk = 1'b0;
    logic       clr_n  = 1'b1;
    logic       oe     = 1'b1;
    logic [3:0] din    = 4'h0;
    logic [3:0] q;
    logic       in_rdy;
    logic       out_rdy;

    int checks = 0;
    int errors = 0;
    logic [3:0] words [16];

    lfifo_top dut (
        .ld_clk(ld_clk), .un_clk(un_clk), .clr_n(clr_n), .oe(oe),
        .din(din), .q(q), .in_rdy(in_rdy), .out_rdy(out_rdy));

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // load pulse; returns input-ready seen in the high phase
    task automatic ld_pulse(input logic [3:0] d, output logic rdy_hi);
        din = d;
        #1;
        ld_clk = 1'b1;
        #2;
        rdy_hi = in_rdy;
        #(HALF - 2);
        ld_clk = 1'b0;
        #3;
    endtask

    // unload pulse; returns output-ready seen in the high phase
    task automatic un_pulse(output logic rdy_hi);
        #1;
        un_clk = 1'b1;
        #2;
        rdy_hi = out_rdy;
        #(HALF - 2);
        un_clk = 1'b0;
        #3;
    endtask

    task automatic load(input logic [3:0] d);
        logic r;
        ld_pulse(d, r);
    endtask

    task automatic flush_rd();
        logic r;
        un_pulse(r);
        un_pulse(r);
    endtask

    task automatic read_word(string req, input logic [3:0] exp, input logic more);
        logic r;
        chk({req, " head word"}, q, exp);
        un_pulse(r);
        chk({req, " out_rdy after read"}, {3'b0, r}, {3'b0, more});
    endtask

    task automatic t_reset();
        logic r;
        #5 clr_n = 1'b0;
        #5;
        chk("R6 in_rdy in clear", {3'b0, in_rdy}, 4'h1);
        un_pulse(r);
        chk("R6 out_rdy in clear", {3'b0, r}, 4'h0);
        clr_n = 1'b1;
        #5;
        load(4'hF);   // R7: both ignored
        load(4'hF);
        flush_rd();
        un_pulse(r);
        chk("R7 early edges ignored", {3'b0, r}, 4'h0);
    endtask

    task automatic t_order();
        logic r;
        load(4'h3); load(4'h9); load(4'hC); load(4'h1); load(4'h6);
        un_pulse(r);
        chk("R10 first sync edge", {3'b0, r}, 4'h0);
        un_pulse(r);
        chk("R10 second sync edge", {3'b0, r}, 4'h1);
        read_word("R1/R9", 4'h3, 1'b1);
        read_word("R1/R9", 4'h9, 1'b1);
        read_word("R1/R9", 4'hC, 1'b1);
        read_word("R1/R9", 4'h1, 1'b1);
        read_word("R1/R9", 4'h6, 1'b0);
        un_pulse(r);
        chk("R3 out_rdy empty", {3'b0, r}, 4'h0);
        un_pulse(r);
        load(4'hB);
        flush_rd();
        read_word("R3 no slip", 4'hB, 1'b0);
    endtask

    task automatic t_levels();
        logic r;
        ld_pulse(4'h7, r);
        chk("R4 in_rdy while ld high", {3'b0, r}, 4'h0);
        chk("R4 in_rdy while ld low", {3'b0, in_rdy}, 4'h1);
        flush_rd();
        chk("R5 out_rdy while un low", {3'b0, out_rdy}, 4'h0);
        read_word("R5", 4'h7, 1'b0);
    endtask

    task automatic t_oe();
        logic r;
        load(4'hA); load(4'h5);
        flush_rd();
        oe = 1'b0;
        #1;
        checks++;
        if (q === 4'hA) begin
            errors++;
            $display("FAIL R8 q not floated: actual %h expected not %h", q, 4'hA);
        end
        chk("R8 in_rdy with oe low", {3'b0, in_rdy}, 4'h1);
        un_pulse(r);
        chk("R8 out_rdy with oe low", {3'b0, r}, 4'h1);
        oe = 1'b1;
        #1;
        read_word("R9 after oe", 4'h5, 1'b0);
    endtask

    task automatic t_clear();
        logic r;
        load(4'h1); load(4'h2); load(4'h3);
        flush_rd();
        chk("R9 head before clear", q, 4'h1);
        clr_n = 1'b0;
        #2;
        chk("R6 in_rdy in clear", {3'b0, in_rdy}, 4'h1);
        un_pulse(r);
        chk("R6 out_rdy in clear", {3'b0, r}, 4'h0);
        clr_n = 1'b1;
        #2;
        load(4'hD); load(4'hD);
        un_pulse(r); un_pulse(r);
        flush_rd();
        un_pulse(r);
        chk("R6 store emptied", {3'b0, r}, 4'h0);
        load(4'h8);
        flush_rd();
        read_word("R6/R7 fresh word", 4'h8, 1'b0);
    endtask

    task automatic t_full();
        logic r;
        for (int i = 0; i < 16; i++) begin
            words[i] = 4'((i * 7 + 2) & 15);
            chk("R1 in_rdy before load", {3'b0, in_rdy}, 4'h1);
            load(words[i]);
        end
        chk("R2 in_rdy at full", {3'b0, in_rdy}, 4'h0);
        for (int i = 0; i < 3; i++) begin
            load(~words[i]);
        end
        flush_rd();
        for (int i = 0; i < 16; i++) begin
            read_word("R1/R2 full order", words[i], (i != 15));
        end
        chk("R10 write side still full", {3'b0, in_rdy}, 4'h0);
        load(4'h0); load(4'h0);
        chk("R10 room seen after two edges", {3'b0, in_rdy}, 4'h1);
        flush_rd();
        un_pulse(r);
        chk("R2 blocked loads stored nothing", {3'b0, r}, 4'h0);
    endtask

    initial begin
        t_reset();
        t_order();
        t_levels();
        t_oe();
        t_clear();
        t_full();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule